// File: doc/BRIEF.md
# Averaging Input Frequency Meter

This block measures the rate of an external square wave that runs with no phase or frequency relation to the system clock. The wave sits roughly between 1 and 4 MHz and can drift by several percent at any moment, so the block measures continuously. The input is first brought into the system clock domain through a two-stage synchronizer. Rising transitions are then detected there. Across a programmable number of input periods, the block accumulates the number of system clock cycles as one running total. Because the total spans all N periods, the quantization error stays near one count for any N, and a larger N yields a finer average period.

Each completed total appears on `raw_count` together with a one-cycle `meas_valid` strobe. The same strobe advances a first-order recursive low-pass filter whose output, `filt_count`, gives a steady value for display. When no rising edge arrives within 2^TMO_W clock cycles, the block raises `no_signal`, abandons the partial window and waits for the wave to return. The first result after reset or after such a loss loads the filter directly.

The controller has three states. `ST_ARM` waits for the rising edge that opens the first window. `ST_COUNT` accumulates cycles and closes a window on every Nth rising edge. `ST_LOST` holds while the input is silent. The transitions are as follows:
- ARM→COUNT on the opening edge.
- COUNT→COUNT on every edge; the closing edge also opens the next window at once.
- ARM→LOST and COUNT→LOST when the edge timeout expires.
- LOST→COUNT on the first edge after the loss.

Top module: `freq_meter_avg`

## Requirements
- R1: While reset is held and right after it is released, `raw_count`, `filt_count`, `meas_valid` and `no_signal` are all 0.
- R2: For a periodic input with a period of P clock cycles and a window length of N, every completed window reports `raw_count` = N*P. The count runs from one rising edge to the Nth rising edge after it.
- R3: Windows run back to back. The rising edge that closes one window opens the next, so a steady input gives an unbroken stream of equal results.
- R4: `num_periods` is sampled when a window opens. A change made while a window is open takes effect from the window after it.
- R5: A `num_periods` value of 0 counts as a window of one period.
- R6: `meas_valid` is a pulse one cycle wide. `raw_count` and `filt_count` change only in the cycle in which `meas_valid` is 1.
- R7: The first result after reset, and the first after a signal loss, load `filt_count` with exactly `raw_count`.
- R8: Each later result updates the filter as y = y + ((x - y) >>> FILT_K), using signed arithmetic with x = `raw_count` (FILT_K = 2 by default). The new `filt_count` therefore lies between its old value and `raw_count`.
- R9: If no rising edge is seen for 2^TMO_W cycles, `no_signal` becomes 1. The open window is dropped and no `meas_valid` occurs while `no_signal` is 1; `raw_count` keeps its last value.
- R10: The first rising edge after a loss clears `no_signal` and opens a fresh window, so the first result after recovery covers a full N periods.
- R11: Only rising edges matter. Two inputs with the same period and different duty cycles give the same count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the counting reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Asynchronous square wave to be measured |
| num_periods | input | PER_W | Number of input periods per window (0 means 1) |
| raw_count | output | CNT_W | Clock cycles counted in the last completed window |
| filt_count | output | CNT_W | Low-pass filtered window count |
| meas_valid | output | 1 | One-cycle strobe marking a new result |
| no_signal | output | 1 | High while the input is considered absent |

## Verification
Some properties are checked on every cycle. `meas_valid` is a lone one-cycle pulse and never occurs while `no_signal` is high. Both outputs hold between strobes. Each filter step lands between the old filtered value and the new raw count, and a raw result is never zero. Other behaviour can only be shown by the bench's scenarios, because it depends on the input history. These are:
- the exact N*P totals for many period, duty and N combinations;
- the one-window delay before a new `num_periods` takes effect;
- timeout entry, and the full first window after recovery;
- reloading of the filter after reset and after a loss.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_COUNT = 2'd1,
        ST_LOST  = 2'd2
    } fm_state_e;

    function automatic int unsigned fm_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        genvar gi;
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign rise = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/fm_window.sv
module fm_window
    import fm_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PER_W = 8,
    parameter int TMO_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [PER_W-1:0] num_periods,
    output logic             close,
    output logic [CNT_W-1:0] close_val,
    output logic             drop,
    output logic             lost
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [PER_W:0]   PER_ONE = (PER_W+1)'(1);
    localparam logic [TMO_W-1:0] TMO_ONE = TMO_W'(1);

    fm_state_e        state_q, state_d;
    logic [CNT_W-1:0] acc_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] n_q;
    logic [TMO_W-1:0] idle_q;
    logic [PER_W:0]   per_inc;
    logic [PER_W-1:0] n_eff;
    logic             idle_exp;
    logic             last_edge;

    assign n_eff     = (num_periods == '0) ? PER_W'(1) : num_periods;
    assign per_inc   = {1'b0, per_q} + PER_ONE;
    assign last_edge = (per_inc >= {1'b0, n_q});
    assign idle_exp  = (&idle_q) & ~rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARM;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM: begin
                if (rise)          state_d = ST_COUNT;
                else if (idle_exp) state_d = ST_LOST;
            end
            ST_COUNT: begin
                if (idle_exp)      state_d = ST_LOST;
            end
            ST_LOST: begin
                if (rise)          state_d = ST_COUNT;
            end
            default:               state_d = ST_ARM;
        endcase
    end

    // outputs
    always_comb begin
        close     = 1'b0;
        close_val = acc_q + CNT_ONE;
        lost      = 1'b0;
        unique case (state_q)
            ST_ARM:   close = 1'b0;
            ST_COUNT: close = rise & last_edge;
            ST_LOST:  lost  = 1'b1;
            default:  close = 1'b0;
        endcase
        drop = (state_q != ST_LOST) && (state_d == ST_LOST);
    end

    // datapath: window accumulator, period counter, edge timeout
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            per_q  <= '0;
            n_q    <= PER_W'(1);
            idle_q <= '0;
        end else begin
            if (rise || state_q == ST_LOST) idle_q <= '0;
            else                            idle_q <= idle_q + TMO_ONE;

            unique case (state_q)
                ST_ARM, ST_LOST: begin
                    acc_q <= '0;
                    if (rise) begin
                        per_q <= '0;
                        n_q   <= n_eff;
                    end
                end
                ST_COUNT: begin
                    if (idle_exp) begin
                        acc_q <= '0;
                        per_q <= '0;
                    end else if (rise) begin
                        if (last_edge) begin
                            acc_q <= '0;
                            per_q <= '0;
                            n_q   <= n_eff;
                        end else begin
                            acc_q <= acc_q + CNT_ONE;
                            per_q <= per_inc[PER_W-1:0];
                        end
                    end else begin
                        acc_q <= acc_q + CNT_ONE;
                    end
                end
                default: acc_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/fm_lpf.sv
module fm_lpf #(
    parameter int CNT_W  = 24,
    parameter int FILT_K = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] x,
    input  logic             reseed,
    output logic [CNT_W-1:0] y
);
    logic               primed_q;
    logic signed [CNT_W:0] diff;
    logic signed [CNT_W:0] step;
    logic signed [CNT_W:0] sum;

    assign diff = $signed({1'b0, x}) - $signed({1'b0, y});
    assign step = diff >>> FILT_K;
    assign sum  = $signed({1'b0, y}) + step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y        <= '0;
            primed_q <= 1'b0;
        end else if (reseed) begin
            primed_q <= 1'b0;
        end else if (load) begin
            primed_q <= 1'b1;
            if (!primed_q) y <= x;
            else           y <= sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/freq_meter_avg.sv
module freq_meter_avg #(
    parameter int CNT_W  = 24,
    parameter int PER_W  = 8,
    parameter int TMO_W  = 9,
    parameter int FILT_K = 2,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [PER_W-1:0] num_periods,
    output logic [CNT_W-1:0] raw_count,
    output logic [CNT_W-1:0] filt_count,
    output logic             meas_valid,
    output logic             no_signal
);
    logic             rise;
    logic             close;
    logic [CNT_W-1:0] close_val;
    logic             drop;

    fm_sync_edge #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sig_in),
        .rise     (rise)
    );

    fm_window #(.CNT_W(CNT_W), .PER_W(PER_W), .TMO_W(TMO_W)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .num_periods (num_periods),
        .close       (close),
        .close_val   (close_val),
        .drop        (drop),
        .lost        (no_signal)
    );

    fm_lpf #(.CNT_W(CNT_W), .FILT_K(FILT_K)) u_lpf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (close),
        .x      (close_val),
        .reseed (drop),
        .y      (filt_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_count  <= '0;
            meas_valid <= 1'b0;
        end else begin
            meas_valid <= close;
            if (close) raw_count <= close_val;
        end
    end

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] raw_count,
    input logic [CNT_W-1:0] filt_count,
    input logic             meas_valid,
    input logic             no_signal
);
    // R6: strobe is a single cycle wide
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

    // R6: raw result holds between strobes
    p_raw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |-> (raw_count == $past(raw_count)));

    // R6: filtered result holds between strobes
    p_filt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |-> (filt_count == $past(filt_count)));

    // R9: no result while the input is absent
    p_quiet_when_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
        no_signal |-> !meas_valid);

    // R8: each filter step lands between old value and new sample
    p_filt_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |->
            (((filt_count >= $past(filt_count)) && (filt_count <= raw_count)) ||
             ((filt_count <= $past(filt_count)) && (filt_count >= raw_count))));

    // R2: a completed window always spans at least one clock cycle
    p_raw_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> (raw_count != '0));

endmodule

bind freq_meter_avg fm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_count  (raw_count),
    .filt_count (filt_count),
    .meas_valid (meas_valid),
    .no_signal  (no_signal)
);

// File: tb/freq_meter_avg_tb.sv
module freq_meter_avg_tb;
    localparam int CNT_W  = 24;
    localparam int PER_W  = 8;
    localparam int TMO_W  = 9;
    localparam int FILT_K = 2;
    localparam int NVEC   = 7;
    // columns: high cycles, low cycles, num_periods
    localparam int VEC [NVEC][3] = '{
        '{20, 20, 4},
        '{31, 31, 8},
        '{62, 63, 2},
        '{ 5, 35, 3},
        '{35,  5, 3},
        '{16, 16, 16},
        '{50, 50, 1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sig_in = 1'b0;
    logic [PER_W-1:0] num_periods = 8'd1;
    logic [CNT_W-1:0] raw_count;
    logic [CNT_W-1:0] filt_count;
    logic             meas_valid;
    logic             no_signal;

    int  checks = 0;
    int  failures = 0;
    int  hi_len = 20;
    int  lo_len = 20;
    bit  wave_en = 1'b0;
    bit  seeded = 1'b0;
    int  y_model = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    freq_meter_avg #(.CNT_W(CNT_W), .PER_W(PER_W), .TMO_W(TMO_W), .FILT_K(FILT_K)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_in      (sig_in),
        .num_periods (num_periods),
        .raw_count   (raw_count),
        .filt_count  (filt_count),
        .meas_valid  (meas_valid),
        .no_signal   (no_signal)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // wave generator
    initial begin
        forever begin
            if (!wave_en) begin
                sig_in = 1'b0;
                @(negedge clk);
            end else begin
                sig_in = 1'b1;
                repeat (hi_len) @(negedge clk);
                sig_in = 1'b0;
                repeat (lo_len) @(negedge clk);
            end
        end
    end

    // filter model, R7 and R8
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n || no_signal) seeded = 1'b0;
            if (rst_n && meas_valid) begin
                if (!seeded) begin
                    y_model = int'(raw_count);
                    seeded  = 1'b1;
                    check(int'(filt_count) == y_model, "R7 filter seed", int'(filt_count), y_model);
                end else begin
                    y_model = y_model + ((int'(raw_count) - y_model) >>> FILT_K);
                    check(int'(filt_count) == y_model, "R8 filter step", int'(filt_count), y_model);
                end
            end
        end
    end

    task automatic wait_valid(output int raw);
        int n;
        raw = -1;
        n = 0;
        while (n < 6000) begin
            @(negedge clk);
            if (meas_valid) begin
                raw = int'(raw_count);
                return;
            end
            n++;
        end
        check(1'b0, "R2 result timeout", 0, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        finish_run();
    end

    initial begin
        int r;
        int exp;
        int raw_hold;
        int vcount;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(raw_count == '0, "R1 raw in reset", int'(raw_count), 0);
        check(filt_count == '0, "R1 filt in reset", int'(filt_count), 0);
        check(meas_valid == 1'b0, "R1 valid in reset", int'(meas_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(no_signal == 1'b0, "R1 no_signal after reset", int'(no_signal), 0);
        check(raw_count == '0 && filt_count == '0, "R1 outputs after reset", int'(raw_count), 0);

        // table walk: R2, R3, R11
        wave_en = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            hi_len      = VEC[i][0];
            lo_len      = VEC[i][1];
            num_periods = PER_W'(VEC[i][2]);
            exp = VEC[i][2] * (VEC[i][0] + VEC[i][1]);
            wait_valid(r);
            wait_valid(r);
            for (int k = 0; k < 2; k++) begin
                wait_valid(r);
                check(r == exp, "R2 R3 R11 window count", r, exp);
            end
        end

        // R4: change taken from the following window
        hi_len = 20; lo_len = 20; num_periods = 8'd2;
        wait_valid(r); wait_valid(r);
        wait_valid(r);
        num_periods = 8'd6;
        wait_valid(r);
        check(r == 80, "R4 old length kept", r, 80);
        wait_valid(r);
        check(r == 240, "R4 new length applied", r, 240);

        // R5: zero means one period
        num_periods = 8'd0;
        wait_valid(r); wait_valid(r);
        wait_valid(r);
        check(r == 40, "R5 zero periods", r, 40);

        // R9: signal loss
        num_periods = 8'd3;
        wait_valid(r); wait_valid(r);
        wait_valid(r);
        raw_hold = r;
        wave_en = 1'b0;
        vcount = 0;
        for (int c = 0; c < (1 << TMO_W) + 300; c++) begin
            @(negedge clk);
            if (no_signal && meas_valid) vcount++;
        end
        check(no_signal == 1'b1, "R9 no_signal raised", int'(no_signal), 1);
        check(vcount == 0, "R9 no strobe while lost", vcount, 0);
        check(int'(raw_count) == raw_hold, "R9 raw kept", int'(raw_count), raw_hold);

        // R10: recovery gives a full window
        hi_len = 10; lo_len = 30;
        wave_en = 1'b1;
        wait_valid(r);
        check(r == 120, "R10 first window after recovery", r, 120);
        check(no_signal == 1'b0, "R10 no_signal cleared", int'(no_signal), 0);
        wait_valid(r);
        check(r == 120, "R10 second window after recovery", r, 120);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule